// File: doc/BRIEF.md
# Parallel Detection Speed Sequencer

This block steers a backplane Ethernet PHY toward a working line rate when the link partner does not negotiate. It watches a pulse that marks each received negotiation page. After a set number of management-clock cycles pass with no page, it starts probing the two line rates. For each probe it asks an external reconfiguration controller to retune the transceiver, and holds the request until that controller acknowledges. It then opens a link-fail-inhibit window sized for the chosen rate and waits for that rate's PCS to report a good link.

If the window closes without a good link, the probe is marked as failed and the sequencer requests the other rate. It keeps alternating between the rates, starting with 10G, until one of them locks. On a lock it reports OK, gives a one-cycle done pulse that names the rate, and stays in that rate. A negotiation page seen at any moment cancels the probing, clears the window and sends the sequencer back to wait for negotiation. A parameter removes the whole detection path, and the block then never requests reconfiguration.

The states are NEG_WAIT (waiting for negotiation or silence), RECONF (request outstanding), INHIBIT (window running) and LOCKED. The transitions are: NEG_WAIT to RECONF on silence timeout; RECONF to INHIBIT on acknowledge; INHIBIT to LOCKED on a good link of the active rate; INHIBIT to RECONF on window expiry, with the rate swapped; and any state except NEG_WAIT to NEG_WAIT on a page.

Top module: `pd_speed_seq`

## Requirements
- R1: While reset is asserted and right after it, reconf_req is 0, done_pulse is 0 and link_status is idle. link_status encodes idle as 2'b00, OK as 2'b01 and FAIL as 2'b10, and the value 2'b11 never appears.
- R2: When SILENCE_CYC consecutive cycles pass in the wait state with no an_page_seen, reconf_req rises on the following cycle with reconf_mode = 1 (10G). reconf_mode and done_rate use 1 for 10G and 0 for 1G. A page pulse during the wait starts the count again.
- R3: reconf_req stays high and reconf_mode stays stable until reconf_ack is sampled high. reconf_req drops in the cycle after the acknowledge.
- R4: The inhibit window starts at the acknowledge. Its length is WIN10_MS*CLK_KHZ cycles for 10G and WIN1_MS*CLK_KHZ cycles for 1G. If no good link is seen during the window, link_status becomes FAIL and reconf_req rises again one window length after it dropped.
- R5: Successive requests alternate 10G, 1G, 10G, and so on.
- R6: If the active rate's link-good input is high in any cycle of the window, including the last one, the next cycle shows done_pulse high for one cycle, link_status OK and done_rate equal to the active rate. The other rate's link-good input has no effect.
- R7: A page pulse in any state gives idle status and no request in the next cycle. Detection then restarts from the silence count, beginning with 10G.
- R8: Once locked, the sequencer makes no more requests and keeps status OK, whatever the link-good inputs do, until a page arrives.
- R9: With DETECT_EN = 0, reconf_req is never raised and link_status stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| an_page_seen | input | 1 | One-cycle pulse per received negotiation page |
| link_good_1g | input | 1 | 1G PCS reports a valid link |
| link_good_10g | input | 1 | 10G PCS reports a valid link |
| reconf_ack | input | 1 | Reconfiguration controller accepted the request |
| reconf_req | output | 1 | Request to retune the transceiver |
| reconf_mode | output | 1 | Target rate of the request (1 = 10G) |
| link_status | output | 2 | 00 idle, 01 OK, 10 FAIL |
| done_pulse | output | 1 | One-cycle pulse when a rate locks |
| done_rate | output | 1 | Rate that locked (1 = 10G) |

## Verification
The bench builds the main instance with CLK_KHZ = 2, which keeps the stated millisecond windows: 504 ms becomes 1008 cycles and 45 ms becomes 90 cycles. It uses SILENCE_CYC = 40. At these sizes several full failed windows of both rates, including exact expiry cycles and a lock in the last window cycle, fit in one short run. A second instance built with DETECT_EN = 0 shares the same inputs, so the disabled variant sees the same silence and link activity as the main instance.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

    typedef enum logic [1:0] {
        LS_IDLE = 2'b00,
        LS_OK   = 2'b01,
        LS_FAIL = 2'b10
    } link_stat_e;

    typedef enum logic [1:0] {
        SQ_NEG_WAIT,
        SQ_RECONF,
        SQ_INHIBIT,
        SQ_LOCKED
    } seq_state_e;

    localparam logic RATE_1G  = 1'b0;
    localparam logic RATE_10G = 1'b1;

endpackage

// File: rtl/pd_limit_counter.sv
module pd_limit_counter #(
    parameter int WIDTH  = 8,
    parameter int LIM_LO = 10,
    parameter int LIM_HI = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic sel_hi,
    output logic hit
);
    localparam logic [WIDTH-1:0] LAST_LO  = WIDTH'(LIM_LO - 1);
    localparam logic [WIDTH-1:0] LAST_HI  = WIDTH'(LIM_HI - 1);
    localparam logic [WIDTH-1:0] LAST_MAX = (LIM_HI > LIM_LO) ? LAST_HI : LAST_LO;

    logic [WIDTH-1:0] cnt;
    logic [WIDTH-1:0] last_sel;

    assign last_sel = sel_hi ? LAST_HI : LAST_LO;
    assign hit      = en && !clr && (cnt == last_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || hit) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the window count never runs past the longer limit
    assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_MAX);

endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
    import pd_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       page,
    input  logic       lg_1g,
    input  logic       lg_10g,
    input  logic       ack,
    input  logic       sil_hit,
    input  logic       win_hit,
    output logic       sil_clr,
    output logic       sil_en,
    output logic       win_clr,
    output logic       win_en,
    output logic       rate,
    output logic       req,
    output logic [1:0] status,
    output logic       done
);
    seq_state_e state, nxt;
    logic       lg_active;

    assign lg_active = rate ? lg_10g : lg_1g;

    assign sil_en  = (state == SQ_NEG_WAIT);
    assign sil_clr = (state != SQ_NEG_WAIT) || page;
    assign win_en  = (state == SQ_INHIBIT);
    assign win_clr = (state != SQ_INHIBIT);

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_NEG_WAIT: if (sil_hit) nxt = SQ_RECONF;
            SQ_RECONF: begin
                if (page)     nxt = SQ_NEG_WAIT;
                else if (ack) nxt = SQ_INHIBIT;
            end
            SQ_INHIBIT: begin
                if (page)           nxt = SQ_NEG_WAIT;
                else if (lg_active) nxt = SQ_LOCKED;
                else if (win_hit)   nxt = SQ_RECONF;
            end
            SQ_LOCKED: if (page) nxt = SQ_NEG_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_NEG_WAIT;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate   <= RATE_10G;
            req    <= 1'b0;
            status <= LS_IDLE;
            done   <= 1'b0;
        end else begin
            req  <= (nxt == SQ_RECONF);
            done <= (state == SQ_INHIBIT) && (nxt == SQ_LOCKED);
            if ((state == SQ_NEG_WAIT) && (nxt == SQ_RECONF))
                rate <= RATE_10G;
            else if ((state == SQ_INHIBIT) && (nxt == SQ_RECONF))
                rate <= ~rate;
            if (nxt == SQ_NEG_WAIT)
                status <= LS_IDLE;
            else if ((state == SQ_INHIBIT) && (nxt == SQ_RECONF))
                status <= LS_FAIL;
            else if ((state == SQ_INHIBIT) && (nxt == SQ_LOCKED))
                status <= LS_OK;
        end
    end

    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req && !ack && !page |=> req);

    assert_mode_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> $stable(rate));

    assert_page_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        page |=> (status == LS_IDLE) && !req);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status == LS_OK));

    assert_status_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);

    assert_locked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == LS_OK) && !page |=> !req && (status == LS_OK));

endmodule

// File: rtl/pd_speed_seq.sv
module pd_speed_seq
    import pd_seq_pkg::*;
#(
    parameter int CLK_KHZ     = 125000,
    parameter int WIN10_MS    = 504,
    parameter int WIN1_MS     = 45,
    parameter int SILENCE_CYC = 1000,
    parameter bit DETECT_EN   = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       an_page_seen,
    input  logic       link_good_1g,
    input  logic       link_good_10g,
    input  logic       reconf_ack,
    output logic       reconf_req,
    output logic       reconf_mode,
    output logic [1:0] link_status,
    output logic       done_pulse,
    output logic       done_rate
);
    localparam int WIN10_CYC = WIN10_MS * CLK_KHZ;
    localparam int WIN1_CYC  = WIN1_MS * CLK_KHZ;
    localparam int WIN_MAX   = (WIN10_CYC > WIN1_CYC) ? WIN10_CYC : WIN1_CYC;
    localparam int WIN_W     = $clog2(WIN_MAX) + 1;
    localparam int SIL_W     = $clog2(SILENCE_CYC) + 1;

    logic sil_clr, sil_en, sil_hit;
    logic win_clr, win_en, win_hit;
    logic rate;

    generate
        if (DETECT_EN) begin : g_detect
            pd_limit_counter #(
                .WIDTH (SIL_W),
                .LIM_LO(SILENCE_CYC),
                .LIM_HI(SILENCE_CYC)
            ) u_silence (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (sil_clr),
                .en    (sil_en),
                .sel_hi(1'b0),
                .hit   (sil_hit)
            );
        end else begin : g_no_detect
            assign sil_hit = 1'b0;
        end
    endgenerate

    pd_limit_counter #(
        .WIDTH (WIN_W),
        .LIM_LO(WIN1_CYC),
        .LIM_HI(WIN10_CYC)
    ) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .en    (win_en),
        .sel_hi(rate),
        .hit   (win_hit)
    );

    pd_seq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .page   (an_page_seen),
        .lg_1g  (link_good_1g),
        .lg_10g (link_good_10g),
        .ack    (reconf_ack),
        .sil_hit(sil_hit),
        .win_hit(win_hit),
        .sil_clr(sil_clr),
        .sil_en (sil_en),
        .win_clr(win_clr),
        .win_en (win_en),
        .rate   (rate),
        .req    (reconf_req),
        .status (link_status),
        .done   (done_pulse)
    );

    assign reconf_mode = rate;
    assign done_rate   = rate;

endmodule

// File: tb/tb_pd_speed_seq.sv
module tb_pd_speed_seq;
    localparam int CLK_KHZ = 2;
    localparam int W10_MS  = 504;
    localparam int W1_MS   = 45;
    localparam int SIL     = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic page = 1'b0, lg1 = 1'b0, lg10 = 1'b0, ack = 1'b0;
    logic req, mode, done, drate;
    logic [1:0] stat;
    logic off_req, off_mode, off_done, off_drate;
    logic [1:0] off_stat;
    logic off_ack = 1'b0;

    int n_chk = 0, n_fail = 0, off_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pd_speed_seq #(.CLK_KHZ(CLK_KHZ), .WIN10_MS(W10_MS), .WIN1_MS(W1_MS),
                   .SILENCE_CYC(SIL), .DETECT_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .an_page_seen(page), .link_good_1g(lg1),
        .link_good_10g(lg10), .reconf_ack(ack), .reconf_req(req),
        .reconf_mode(mode), .link_status(stat), .done_pulse(done), .done_rate(drate));

    pd_speed_seq #(.CLK_KHZ(CLK_KHZ), .WIN10_MS(W10_MS), .WIN1_MS(W1_MS),
                   .SILENCE_CYC(SIL), .DETECT_EN(1'b0)) dut_off (
        .clk(clk), .rst_n(rst_n), .an_page_seen(page), .link_good_1g(lg1),
        .link_good_10g(lg10), .reconf_ack(off_ack), .reconf_req(off_req),
        .reconf_mode(off_mode), .link_status(off_stat), .done_pulse(off_done),
        .done_rate(off_drate));

    function automatic int win_cyc(input bit r10);
        return r10 ? W10_MS * CLK_KHZ : W1_MS * CLK_KHZ;
    endfunction

    function automatic bit exp_rate(input int idx);
        return (idx % 2) == 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n && (off_req || off_stat != 2'b00 || off_done)) off_bad++;

    task automatic do_reset();
        rst_n = 1'b0; page = 0; lg1 = 0; lg10 = 0; ack = 0;
        repeat (3) @(negedge clk);
        check(req == 0 && done == 0, "R1 req/done in reset", {req, done}, 0);
        check(stat == 2'b00, "R1 status in reset", stat, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req == 0 && stat == 2'b00, "R1 after release", {stat, req}, 0);
        // one cycle of silence already elapsed; wait_sil accounts for it
    endtask

    // Starts at a negedge where the wait count is at 'already' cycles.
    task automatic wait_sil(input int already, input string tag);
        int n = already;
        while (!req && n < SIL + 10) begin
            @(negedge clk);
            n++;
        end
        check(n == SIL, tag, n, SIL);
        check(mode == 1'b1, "R2 first request is 10G", mode, 1);
    endtask

    // Precondition: at a negedge with req high.
    task automatic attempt(input bit er, input int lat, input int link_at, input bit wrong);
        int c;
        int w = win_cyc(er);
        check(mode == er, "R5 alternating rate", mode, er);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            check(req == 1 && mode == er, "R3 request held before ack", {req, mode}, {1'b1, er});
        end
        ack = 1;
        if (wrong) begin
            if (er) lg1 = 1; else lg10 = 1;
        end
        @(negedge clk);
        ack = 0;
        c = 1;
        check(req == 0, "R3 request drops after ack", req, 0);
        if (link_at > 0) begin
            while (c < link_at) begin
                @(negedge clk);
                c++;
            end
            check(req == 0 && done == 0, "R6 no early lock", {req, done}, 0);
            if (er) lg10 = 1; else lg1 = 1;
            @(negedge clk);
            check(done == 1, "R6 done pulse", done, 1);
            check(stat == 2'b01, "R6 status OK", stat, 1);
            check(drate == er, "R6 done rate", drate, er);
            @(negedge clk);
            check(done == 0, "R6 done single cycle", done, 0);
            lg1 = 0; lg10 = 0;
            repeat (w + 20) @(negedge clk);
            lg1 = 1;
            repeat (5) @(negedge clk);
            check(req == 0 && stat == 2'b01, "R8 stays locked", {stat, req}, 3'b010);
            lg1 = 0;
        end else begin
            while (!req && c < w + 5) begin
                @(negedge clk);
                c++;
            end
            check(c == w + 1, "R4 window length", c, w + 1);
            check(stat == 2'b10, "R4 status FAIL", stat, 2);
            lg1 = 0; lg10 = 0;
        end
    endtask

    task automatic page_pulse();
        page = 1;
        @(negedge clk);
        page = 0;
        check(stat == 2'b00 && req == 0, "R7 page gives idle", {stat, req}, 0);
    endtask

    initial begin
        int unsigned s;
        s = $urandom(32'd7331);
        // Directed: silence, full fail of each rate, lock on last window cycle
        do_reset();
        wait_sil(1, "R2 silence length");
        check(stat == 2'b00, "R1 idle before first fail", stat, 0);
        attempt(exp_rate(0), 3, 0, 1'b1);
        attempt(exp_rate(1), 0, 0, 1'b1);
        attempt(exp_rate(2), 1, 0, 1'b0);
        attempt(exp_rate(3), 2, win_cyc(1'b0), 1'b0);
        page_pulse();
        wait_sil(0, "R7 restart after page from lock");

        // Page during the inhibit window, and page during the wait
        ack = 1;
        @(negedge clk);
        ack = 0;
        repeat (100) @(negedge clk);
        page_pulse();
        repeat (10) @(negedge clk);
        check(req == 0, "R7 no request while silence restarts", req, 0);
        page_pulse();
        wait_sil(0, "R2 page restarts silence count");

        // Page while request outstanding
        repeat (3) @(negedge clk);
        page_pulse();
        wait_sil(0, "R7 restart after page in request");
        attempt(exp_rate(0), 0, win_cyc(1'b1), 1'b1);
        page_pulse();

        // Random trials
        for (int t = 0; t < 10; t++) begin
            int nf;
            int k;
            int la;
            bit er;
            do_reset();
            wait_sil(1, "R2 silence length random");
            nf = $urandom_range(0, 3);
            for (int i = 0; i < nf; i++)
                attempt(exp_rate(i), $urandom_range(0, 6), 0, 1'($urandom_range(0, 1)));
            er = exp_rate(nf);
            k = $urandom_range(0, 2);
            la = (k == 0) ? 1 : (k == 1) ? win_cyc(er) : $urandom_range(1, win_cyc(er));
            attempt(er, $urandom_range(0, 6), la, 1'($urandom_range(0, 1)));
            page_pulse();
        end

        check(off_bad == 0, "R9 disabled instance stays quiet", off_bad, 0);
        check(off_req == 0 && off_stat == 2'b00, "R9 disabled outputs", {off_stat, off_req}, 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule